// File: doc/BRIEF.md
# Serial Flash Erase Command Gate

This block is the command front end of an SPI slave that behaves like a serial flash. It oversamples the SPI pins with a system clock. While chip select is low it shifts opcode bits in, and it keeps a write-enable latch. On a valid whole-array erase command it runs a self-timed erase cycle over a small internal byte array. Progress shows in a status byte that the host reads back over the same bus.

The erase is guarded on three counts:
- the write-enable latch must be set;
- all three block-protect bits must be zero;
- chip select must rise exactly when the eighth opcode bit has been taken in.

If any guard fails, the command is dropped silently. During the erase the write-in-progress flag reads 1. When the cycle ends, every array byte becomes FFh and the flag and the write-enable latch clear together. The array has a plain combinational read port so that its contents can be observed.

Top module: `flash_erase_gate`

## Requirements
- R1: After reset the status byte is 00h with the protect field equal to `prot_init`, `miso` is 0, and every array byte reads 00h.
- R2: Opcode 06h, followed by chip select rising after exactly 8 bits, sets the write-enable latch (status bit 1).
- R3: After opcode 05h, the status byte is driven on `miso` MSB first, changing on SCK falling edges (SPI mode 0). It repeats every 8 further clocks. Layout: bit 0 is write-in-progress, bit 1 is write-enable, bits 4:2 are protect, bits 7:5 are zero.
- R4: Opcode C7h is accepted when chip select rises after exactly 8 bits, the write-enable latch is set and the protect bits are 000. Write-in-progress then becomes 1 and stays 1 for `ERASE_CYCLES` system clocks.
- R5: At the end of the erase cycle every array byte reads FFh, and write-in-progress and write-enable both return to 0 on the same clock.
- R6: Erase with the write-enable latch clear is ignored: the array is unchanged and write-in-progress stays 0.
- R7: Erase with any protect bit set is ignored: the array is unchanged and the write-enable latch stays 1.
- R8: Erase with chip select rising after 7 or 9 bits is ignored: the array is unchanged and the write-enable latch stays 1.
- R9: While write-in-progress is 1, further 06h and C7h commands are ignored. The running cycle is neither restarted nor extended, and the latch is 0 after it ends.
- R10: The status byte can be read during an erase and shows write-in-progress = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI pins are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prot_init | input | 3 | Protect bits captured at reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI serial data in |
| miso | output | 1 | SPI serial data out (status byte) |
| rd_addr | input | $clog2(ARRAY_DEPTH) | Array observation address |
| rd_data | output | 8 | Array byte at `rd_addr` |

## Verification
The assertions rely on two assumptions about the inputs:
- SCK is slow compared with the system clock, so every SPI edge survives the two-stage synchronizer as a separate event.
- Chip select never changes in the same oversampled cycle as an SCK edge.

The bench keeps to both. It holds each SCK phase for eight system clocks, and it moves chip select only half an SCK period away from the last SCK edge. All pins are driven on the falling system-clock edge, so every edge is seen a fixed, known number of clocks later.

// File: rtl/flash_gate_pkg.sv
package flash_gate_pkg;
  localparam logic [7:0] OP_WRITE_EN = 8'h06;
  localparam logic [7:0] OP_STATUS   = 8'h05;
  localparam logic [7:0] OP_ERASE    = 8'hC7;

  typedef struct packed {
    logic [2:0] rsvd;
    logic [2:0] prot;
    logic       wel;
    logic       wip;
  } status_t;
endpackage

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
  import flash_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  input  status_t    status_i,
  output logic       cmd_stb_o,
  output logic [7:0] cmd_op_o,
  output logic       miso_o
);
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] OP_BITS  = CNT_W'(8);

  logic [2:0] sync1_q, sync2_q;
  logic       sck_d_q, cs_d_q;
  logic       sck_s, cs_s, mosi_s;
  logic       sck_rise, sck_fall, cs_rise;

  logic [CNT_W-1:0] bit_cnt_q, bit_cnt_d;
  logic [7:0]       shift_q, shift_d;
  logic [7:0]       op_q, op_d;
  logic             rd_mode_q, rd_mode_d;
  logic [7:0]       tx_q, tx_d;
  logic [2:0]       tx_cnt_q, tx_cnt_d;
  logic             miso_q, miso_d;
  logic [7:0]       op_in;

  // two-stage synchronizer for {sck, cs_n, mosi}
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 3'b010;
      sync2_q <= 3'b010;
      sck_d_q <= 1'b0;
      cs_d_q  <= 1'b1;
    end else begin
      sync1_q <= {sck, cs_n, mosi};
      sync2_q <= sync1_q;
      sck_d_q <= sync2_q[2];
      cs_d_q  <= sync2_q[1];
    end
  end

  assign sck_s    = sync2_q[2];
  assign cs_s     = sync2_q[1];
  assign mosi_s   = sync2_q[0];
  assign sck_rise = sck_s & ~sck_d_q;
  assign sck_fall = ~sck_s & sck_d_q;
  assign cs_rise  = cs_s & ~cs_d_q;
  assign op_in    = {shift_q[6:0], mosi_s};

  always_comb begin
    bit_cnt_d = bit_cnt_q;
    shift_d   = shift_q;
    op_d      = op_q;
    rd_mode_d = rd_mode_q;
    tx_d      = tx_q;
    tx_cnt_d  = tx_cnt_q;
    miso_d    = miso_q;
    if (cs_s) begin
      bit_cnt_d = '0;
      rd_mode_d = 1'b0;
      tx_cnt_d  = '0;
      miso_d    = 1'b0;
    end else begin
      if (sck_rise) begin
        shift_d = op_in;
        if (bit_cnt_q != CNT_MAX) bit_cnt_d = bit_cnt_q + 1'b1;
        if (bit_cnt_q == OP_BITS - 1'b1) begin
          op_d = op_in;
          if (op_in == OP_STATUS) rd_mode_d = 1'b1;
        end
      end
      if (sck_fall && rd_mode_q) begin
        if (tx_cnt_q == 3'd0) begin
          miso_d   = status_i[7];
          tx_d     = {status_i[6:0], 1'b0};
          tx_cnt_d = 3'd7;
        end else begin
          miso_d   = tx_q[7];
          tx_d     = {tx_q[6:0], 1'b0};
          tx_cnt_d = tx_cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= '0;
      shift_q   <= '0;
      op_q      <= '0;
      rd_mode_q <= 1'b0;
      tx_q      <= '0;
      tx_cnt_q  <= '0;
      miso_q    <= 1'b0;
    end else begin
      bit_cnt_q <= bit_cnt_d;
      shift_q   <= shift_d;
      op_q      <= op_d;
      rd_mode_q <= rd_mode_d;
      tx_q      <= tx_d;
      tx_cnt_q  <= tx_cnt_d;
      miso_q    <= miso_d;
    end
  end

  assign cmd_stb_o = cs_rise & (bit_cnt_q == OP_BITS);
  assign cmd_op_o  = op_q;
  assign miso_o    = miso_q;

  // R3
  miso_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso_q) |-> ($past(sck_fall) || $past(cs_s)));

  // R8
  strobe_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb_o |-> $past(!cs_s));
endmodule

// File: rtl/erase_ctrl.sv
module erase_ctrl
  import flash_gate_pkg::*;
#(
  parameter int ERASE_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] prot_init,
  input  logic       cmd_stb_i,
  input  logic [7:0] cmd_op_i,
  output status_t    status_o,
  output logic       fill_o
);
  localparam int TIMER_W = $clog2(ERASE_CYCLES + 1);
  localparam logic [TIMER_W-1:0] TIMER_LOAD = TIMER_W'(ERASE_CYCLES - 1);

  logic [2:0]         prot_q;
  logic               wel_q, wel_d;
  logic               wip_q, wip_d;
  logic [TIMER_W-1:0] timer_q, timer_d;
  logic               take_erase, take_wren, cycle_done;

  assign take_erase = cmd_stb_i & (cmd_op_i == OP_ERASE) & wel_q &
                      (prot_q == 3'b000) & ~wip_q;
  assign take_wren  = cmd_stb_i & (cmd_op_i == OP_WRITE_EN) & ~wip_q;
  assign cycle_done = wip_q & (timer_q == '0);

  always_comb begin
    wip_d   = wip_q;
    wel_d   = wel_q;
    timer_d = timer_q;
    if (take_erase) begin
      wip_d   = 1'b1;
      timer_d = TIMER_LOAD;
    end else if (cycle_done) begin
      wip_d = 1'b0;
    end else if (wip_q) begin
      timer_d = timer_q - 1'b1;
    end
    if (take_wren)       wel_d = 1'b1;
    else if (cycle_done) wel_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q  <= prot_init;
      wel_q   <= 1'b0;
      wip_q   <= 1'b0;
      timer_q <= '0;
    end else begin
      wel_q   <= wel_d;
      wip_q   <= wip_d;
      timer_q <= timer_d;
    end
  end

  assign status_o = '{rsvd: 3'b000, prot: prot_q, wel: wel_q, wip: wip_q};
  assign fill_o   = cycle_done;

  // R4
  erase_guarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip_q) |-> ($past(wel_q) && $past(cmd_stb_i) && (prot_q == 3'b000)));

  // R4
  wip_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wip_q && timer_q != '0) |=> wip_q);

  // R5
  wel_clear_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wel_q) |-> $fell(wip_q));

  // R9
  no_wren_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> !$past(wip_q));
endmodule

// File: rtl/fill_array.sv
module fill_array #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0] mem_q [DEPTH];
  logic [7:0] mem_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = fill_i ? 8'hFF : mem_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  // R5
  fill_sets_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_i |=> (mem_q[0] == 8'hFF && mem_q[DEPTH-1] == 8'hFF));

  // R6
  change_only_on_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_q[0]) |-> $past(fill_i));
endmodule

// File: rtl/flash_erase_gate.sv
module flash_erase_gate
  import flash_gate_pkg::*;
#(
  parameter int ARRAY_DEPTH  = 16,
  parameter int ERASE_CYCLES = 1000,
  localparam int ADDR_W      = $clog2(ARRAY_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        prot_init,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  status_t    status;
  logic       cmd_stb;
  logic [7:0] cmd_op;
  logic       fill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  spi_cmd_frontend u_front (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sck      (sck),
    .cs_n     (cs_n),
    .mosi     (mosi),
    .status_i (status),
    .cmd_stb_o(cmd_stb),
    .cmd_op_o (cmd_op),
    .miso_o   (miso)
  );

  erase_ctrl #(.ERASE_CYCLES(ERASE_CYCLES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .prot_init(prot_init),
    .cmd_stb_i(cmd_stb),
    .cmd_op_i (cmd_op),
    .status_o (status),
    .fill_o   (fill)
  );

  fill_array #(.DEPTH(ARRAY_DEPTH), .AW(ADDR_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .fill_i   (fill),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );
endmodule

// File: tb/flash_erase_gate_test.sv
module flash_erase_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int DEPTH      = 16;
  localparam int ERASE_N    = 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] prot_init = 3'b000;
  logic       sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic       miso;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  int cyc = 0;
  int checks = 0, failures = 0;
  int t_rise = 0;

  flash_erase_gate #(.ARRAY_DEPTH(DEPTH), .ERASE_CYCLES(ERASE_N)) uut (
    .clk(clk), .rst_n(rst_n), .prot_init(prot_init), .sck(sck), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [2:0] p);
    @(negedge clk);
    rst_n = 1'b0; prot_init = p; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0;
    wait_clks(3);
    rst_n = 1'b1;
    wait_clks(6);
  endtask

  task automatic sel;
    @(negedge clk); cs_n = 1'b0; wait_clks(HALF);
  endtask

  task automatic desel;
    wait_clks(HALF); cs_n = 1'b1; t_rise = cyc; wait_clks(2*HALF);
  endtask

  // shifts out the top nbits of b, MSB first, returning what miso held at each rising SCK
  task automatic xfer(input logic [7:0] b, input int nbits, output logic [7:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      mosi = b[7-i];
      wait_clks(HALF);
      got = {got[6:0], miso};
      sck = 1'b1;
      wait_clks(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic command(input logic [7:0] op, input int nbits);
    logic [7:0] dummy;
    sel();
    xfer(op, nbits > 8 ? 8 : nbits, dummy);
    if (nbits > 8) xfer(8'h00, nbits - 8, dummy);
    desel();
  endtask

  task automatic read_status(output logic [7:0] s0, output logic [7:0] s1);
    logic [7:0] dummy;
    sel();
    xfer(8'h05, 8, dummy);
    xfer(8'h00, 8, s0);
    xfer(8'h00, 8, s1);
    desel();
  endtask

  task automatic check_array(input string req, input logic [7:0] exp);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk); rd_addr = 4'(a); #1;
      check(req, rd_data, exp);
    end
  endtask

  task automatic test_reset;
    logic [7:0] s0, s1;
    do_reset(3'b000);
    check("R1 miso", miso, 0);
    check_array("R1 array", 8'h00);
    read_status(s0, s1);
    check("R1 status", s0, 8'h00);
    check("R3 repeat", s1, 8'h00);
  endtask

  task automatic test_no_wel;
    logic [7:0] s0, s1;
    do_reset(3'b000);
    command(8'hC7, 8);
    wait_clks(ERASE_N + 20);
    read_status(s0, s1);
    check("R6 status", s0, 8'h00);
    check_array("R6 array", 8'h00);
  endtask

  task automatic test_bad_count;
    logic [7:0] s0, s1;
    do_reset(3'b000);
    command(8'h06, 8);
    read_status(s0, s1);
    check("R2 wel set", s0, 8'h02);
    command(8'hC7, 7);
    wait_clks(40);
    read_status(s0, s1);
    check("R8 7 bits", s0, 8'h02);
    command(8'hC7, 9);
    wait_clks(ERASE_N + 20);
    read_status(s0, s1);
    check("R8 9 bits", s0, 8'h02);
    check_array("R8 array", 8'h00);
  endtask

  task automatic test_protect;
    logic [7:0] s0, s1;
    do_reset(3'b101);
    command(8'h06, 8);
    read_status(s0, s1);
    check("R3 prot field", s0, 8'h16);
    command(8'hC7, 8);
    wait_clks(ERASE_N + 20);
    read_status(s0, s1);
    check("R7 status", s0, 8'h16);
    check_array("R7 array", 8'h00);
  endtask

  task automatic test_erase;
    logic [7:0] s0, s1;
    int t0;
    do_reset(3'b000);
    command(8'h06, 8);
    sel();
    xfer(8'hC7, 8, s0);
    wait_clks(HALF); cs_n = 1'b1; t0 = cyc;
    wait_clks(2*HALF);
    read_status(s0, s1);
    check("R10 busy", s0, 8'h03);
    check("R4 busy", s1, 8'h03);
    command(8'h06, 8);   // R9: must not survive the cycle end
    command(8'hC7, 8);   // R9: must not restart the timer
    while (cyc < t0 + ERASE_N + 1) @(negedge clk);
    rd_addr = 4'd0; #1;
    check("R4 still erasing", rd_data, 8'h00);
    while (cyc < t0 + ERASE_N + 4) @(negedge clk);
    #1;
    check("R5 done", rd_data, 8'hFF);
    check_array("R5 array", 8'hFF);
    read_status(s0, s1);
    check("R5 R9 status", s0, 8'h00);
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    test_reset();
    test_no_wel();
    test_bad_count();
    test_protect();
    test_erase();
    report();
  end
endmodule